// File: doc/BRIEF.md
# Transmit-Context Completion Interrupt Register Block

This block gathers DMA completion interrupts from up to eight transmit contexts. It holds them in an event register and gates them with a mask register. It drives one registered summary line to a higher-level interrupt controller. Each context sends a one-cycle completion pulse together with the two-bit interrupt-control field of the command that finished. Only the "always interrupt" code records an event.

Software reaches both registers over a plain 32-bit strobe bus. Each register has two write offsets: a set offset and a clear offset. A one in the write data sets or clears the matching bit, and a zero leaves that bit alone. Reading the event register at its clear offset returns the masked view.

The parameter `NUM_CTX` chooses how many low-order contexts exist. Bits above that count are tied to zero, so software can write all ones to the mask and read it back to find which contexts are present. The register bus uses single-cycle strobes with no back-pressure. A write takes effect at the clock edge where `reg_wr` is high. Read data is captured at the edge where `reg_rd` is high.

Top module: `ctxirq_top`

## Requirements
- R1: After reset the event bits and mask bits are zero, `irq_out` is low and `reg_rdata` is zero.
- R2: A write to offset 0x90 sets every event bit whose write-data bit is one. Event bits whose write-data bit is zero keep their value.
- R3: A write to offset 0x94 clears every event bit whose write-data bit is one. A write to offset 0x9C does the same for the mask bits. Bits written with zero keep their value.
- R4: A write to offset 0x98 sets every mask bit whose write-data bit is one and leaves the others alone. A read of 0x98 or 0x9C returns the mask bits.
- R5: A read of 0x90 returns the raw event bits. A read of 0x94 returns the event bits ANDed with the mask bits.
- R6: Read-data bits 31:8 are always zero. Any offset other than 0x90, 0x94, 0x98 and 0x9C reads as zero. Bit k of the register data (k = 0..7) belongs to context k.
- R7: A completion pulse on context k sets event bit k only when that context's field `cmpl_irq_ctl[2k+1:2k]` equals 2'b11. The values 00, 01 and 10 set nothing.
- R8: If a qualified completion and a clear write hit the same event bit in the same cycle, the bit ends up set.
- R9: `irq_out` is registered. It equals the OR of (event AND mask) as it stood one clock earlier, so it follows a bit change by exactly one cycle. A set written through 0x90 raises it just as a completion does.
- R10: Event and mask bits at positions NUM_CTX and above can never be set, and they read as zero at every offset.
- R11: `reg_rdata` is loaded at the clock edge where `reg_rd` is high. It keeps that value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_pulse | input | 8 | One-cycle completion pulse, one bit per context |
| cmpl_irq_ctl | input | 16 | Interrupt-control field per context, bits [2k+1:2k] for context k |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Registered summary interrupt |

## Verification
A write or a completion pulse changes the register bits at the edge where it is presented. Read data appears at the edge of the read strobe, so the bench samples both on the falling edge that follows. The summary line comes one edge later still. For that reason the bench checks `irq_out` once at the first falling edge after a write, expecting the old value, and again one cycle on, expecting the new value. Every other check reads the registers back through the bus after the causing stimulus has retired. The bench sweeps all context and field combinations and all 256 mask patterns. It runs a five-context instance beside the full one.

// File: rtl/ctxirq_pkg.sv
package ctxirq_pkg;
  localparam int CTX_W  = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_EV_SET = 8'h90;
  localparam logic [ADDR_W-1:0] OFS_EV_CLR = 8'h94;
  localparam logic [ADDR_W-1:0] OFS_MK_SET = 8'h98;
  localparam logic [ADDR_W-1:0] OFS_MK_CLR = 8'h9C;

  localparam logic [1:0] IRQ_ALWAYS = 2'b11;

  typedef struct packed {
    logic [CTX_W-1:0] ev_set;
    logic [CTX_W-1:0] ev_clr;
    logic [CTX_W-1:0] mk_set;
    logic [CTX_W-1:0] mk_clr;
  } wr_strobes_t;
endpackage

// File: rtl/ctxirq_wdec.sv
module ctxirq_wdec
  import ctxirq_pkg::*;
(
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output wr_strobes_t       strb
);
  logic unused_wdata_hi;
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CTX_W];

  always_comb begin
    strb = '0;
    if (reg_wr) begin
      unique case (reg_addr)
        OFS_EV_SET: strb.ev_set = reg_wdata[CTX_W-1:0];
        OFS_EV_CLR: strb.ev_clr = reg_wdata[CTX_W-1:0];
        OFS_MK_SET: strb.mk_set = reg_wdata[CTX_W-1:0];
        OFS_MK_CLR: strb.mk_clr = reg_wdata[CTX_W-1:0];
        default:    strb = '0;
      endcase
    end
  end
endmodule

// File: rtl/ctxirq_qual.sv
module ctxirq_qual
  import ctxirq_pkg::*;
(
  input  logic [CTX_W-1:0]   cmpl_pulse,
  input  logic [2*CTX_W-1:0] cmpl_irq_ctl,
  output logic [CTX_W-1:0]   hw_set
);
  for (genvar i = 0; i < CTX_W; i++) begin : g_ctx
    assign hw_set[i] = cmpl_pulse[i] && (cmpl_irq_ctl[2*i+1:2*i] == IRQ_ALWAYS);
  end
endmodule

// File: rtl/ctxirq_bank.sv
module ctxirq_bank
  import ctxirq_pkg::*;
#(
  parameter int NUM_IMPL = CTX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTX_W-1:0] hw_set,
  input  logic [CTX_W-1:0] sw_set,
  input  logic [CTX_W-1:0] sw_clr,
  output logic [CTX_W-1:0] bits
);
  localparam int unsigned    IMPL_INT = (1 << NUM_IMPL) - 1;
  localparam logic [CTX_W-1:0] IMPL   = IMPL_INT[CTX_W-1:0];

  for (genvar i = 0; i < CTX_W; i++) begin : g_bit
    if (i < NUM_IMPL) begin : g_impl
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n)                   q <= 1'b0;
        else if (hw_set[i] | sw_set[i]) q <= 1'b1;
        else if (sw_clr[i])           q <= 1'b0;
      end
      assign bits[i] = q;
    end else begin : g_tied
      assign bits[i] = 1'b0;
    end
  end

  // R8: any set, hardware or software, lands even when a clear coincides
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (((hw_set | sw_set) & IMPL) != '0) |=>
      ((bits & $past((hw_set | sw_set) & IMPL)) == $past((hw_set | sw_set) & IMPL)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_clr & ~hw_set & ~sw_set & IMPL) != '0) |=>
      ((bits & $past(sw_clr & ~hw_set & ~sw_set)) == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((hw_set | sw_set | sw_clr) == '0) |=> $stable(bits));

  p_unimpl_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bits & ~IMPL) == '0);
endmodule

// File: rtl/ctxirq_rdmux.sv
module ctxirq_rdmux
  import ctxirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CTX_W-1:0]  ev,
  input  logic [CTX_W-1:0]  mk,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [CTX_W-1:0] sel;

  always_comb begin
    unique case (reg_addr)
      OFS_EV_SET:             sel = ev;
      OFS_EV_CLR:             sel = ev & mk;
      OFS_MK_SET, OFS_MK_CLR: sel = mk;
      default:                sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= {{(DATA_W-CTX_W){1'b0}}, sel};
  end

  p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:CTX_W] == '0);

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: rtl/ctxirq_top.sv
module ctxirq_top
  import ctxirq_pkg::*;
#(
  parameter int NUM_CTX = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CTX_W-1:0]      cmpl_pulse,
  input  logic [2*CTX_W-1:0]    cmpl_irq_ctl,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_wr,
  input  logic [DATA_W-1:0]     reg_wdata,
  input  logic                  reg_rd,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic                  irq_out
);
  wr_strobes_t      strb;
  logic [CTX_W-1:0] hw_set;
  logic [CTX_W-1:0] ev_bits;
  logic [CTX_W-1:0] mk_bits;

  ctxirq_wdec u_wdec (
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .strb      (strb)
  );

  ctxirq_qual u_qual (
    .cmpl_pulse   (cmpl_pulse),
    .cmpl_irq_ctl (cmpl_irq_ctl),
    .hw_set       (hw_set)
  );

  ctxirq_bank #(.NUM_IMPL(NUM_CTX)) u_event (
    .clk    (clk),
    .rst_n  (rst_n),
    .hw_set (hw_set),
    .sw_set (strb.ev_set),
    .sw_clr (strb.ev_clr),
    .bits   (ev_bits)
  );

  ctxirq_bank #(.NUM_IMPL(NUM_CTX)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .hw_set ({CTX_W{1'b0}}),
    .sw_set (strb.mk_set),
    .sw_clr (strb.mk_clr),
    .bits   (mk_bits)
  );

  ctxirq_rdmux u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .ev        (ev_bits),
    .mk        (mk_bits),
    .reg_rdata (reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= |(ev_bits & mk_bits);
  end

  p_irq_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == ($past(ev_bits & mk_bits) != '0)));

  p_hw_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_pulse[0] && cmpl_irq_ctl[1:0] == IRQ_ALWAYS) |=> ev_bits[0]);
endmodule

// File: tb/tb_ctxirq_top.sv
module tb_ctxirq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cmpl_pulse = '0;
  logic [15:0] cmpl_irq_ctl = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata, reg_rdata5;
  logic        irq_out, irq_out5;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] m_ev = '0;
  logic [7:0] m_mk = '0;
  localparam logic [7:0] IMPL5 = 8'h1F;

  always #4 clk = ~clk;

  ctxirq_top #(.NUM_CTX(8)) dut (
    .clk(clk), .rst_n(rst_n), .cmpl_pulse(cmpl_pulse), .cmpl_irq_ctl(cmpl_irq_ctl),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .irq_out(irq_out));

  ctxirq_top #(.NUM_CTX(5)) dut5 (
    .clk(clk), .rst_n(rst_n), .cmpl_pulse(cmpl_pulse), .cmpl_irq_ctl(cmpl_irq_ctl),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata5), .irq_out(irq_out5));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      8'h90: m_ev = m_ev | d[7:0];
      8'h94: m_ev = m_ev & ~d[7:0];
      8'h98: m_mk = m_mk | d[7:0];
      8'h9C: m_mk = m_mk & ~d[7:0];
      default: ;
    endcase
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v, output logic [31:0] v5);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata; v5 = reg_rdata5;
  endtask

  task automatic pulse(input int c, input logic [1:0] ctl);
    cmpl_pulse = 8'(1 << c);
    cmpl_irq_ctl = 16'(ctl) << (2 * c);
    @(negedge clk);
    cmpl_pulse = '0; cmpl_irq_ctl = '0;
    if (ctl == 2'b11) m_ev = m_ev | 8'(1 << c);
  endtask

  function automatic logic [31:0] ev_exp(input logic [7:0] imp);
    return {24'h0, m_ev & imp};
  endfunction

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, v5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'h0, irq_out}, 32'h0);
    chk("R1 rdata", reg_rdata, 32'h0);
    rd(8'h90, v, v5); chk("R1 event", v, 32'h0);
    rd(8'h98, v, v5); chk("R1 mask", v, 32'h0);

    // R7 sweep every context and every field code
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 4; k++) begin
        pulse(c, 2'(k));
        rd(8'h90, v, v5);
        chk("R7 event", v, ev_exp(8'hFF));
        chk("R10 event5", v5, ev_exp(IMPL5));
        wr(8'h94, 32'hFF);
      end
    end

    // R2 / R3 set and clear with zero bits preserved
    wr(8'h90, 32'h5A); rd(8'h90, v, v5); chk("R2 set", v, 32'h5A);
    wr(8'h90, 32'h01); rd(8'h90, v, v5); chk("R2 keep", v, 32'h5B);
    wr(8'h94, 32'h0A); rd(8'h90, v, v5); chk("R3 clear", v, 32'h51);
    chk("R3 model", v, ev_exp(8'hFF));

    // R6 reserved bits and unmapped offsets
    wr(8'h90, 32'hFFFF_FF00); rd(8'h90, v, v5); chk("R6 rsvd", v, 32'h51);
    rd(8'h80, v, v5); chk("R6 unmapped", v, 32'h0);
    rd(8'h91, v, v5); chk("R6 unmapped2", v, 32'h0);

    // R4 / R5 / R9 exhaustive mask sweep
    wr(8'h94, 32'hFF); wr(8'h90, 32'hA5);
    for (int m = 0; m < 256; m++) begin
      wr(8'h9C, 32'hFF);
      wr(8'h98, 32'(m));
      @(negedge clk);
      chk("R9 irq", {31'h0, irq_out}, {31'h0, |(m_ev & m_mk)});
      chk("R10 irq5", {31'h0, irq_out5}, {31'h0, |(m_ev & m_mk & IMPL5)});
      rd(8'h98, v, v5); chk("R4 mask set rd", v, {24'h0, m_mk});
      chk("R10 mask5", v5, {24'h0, m_mk & IMPL5});
      rd(8'h9C, v, v5); chk("R4 mask clr rd", v, {24'h0, m_mk});
      rd(8'h94, v, v5); chk("R5 masked", v, {24'h0, m_ev & m_mk});
      rd(8'h90, v, v5); chk("R5 raw", v, ev_exp(8'hFF));
    end

    // R9 latency: software set raises irq one cycle after bit changes
    wr(8'h94, 32'hFF); wr(8'h9C, 32'hFF); wr(8'h98, 32'h01);
    @(negedge clk);
    chk("R9 idle", {31'h0, irq_out}, 32'h0);
    wr(8'h90, 32'h01);
    chk("R9 not yet", {31'h0, irq_out}, 32'h0);
    @(negedge clk);
    chk("R9 raised", {31'h0, irq_out}, 32'h1);
    wr(8'h94, 32'h01);
    chk("R9 still", {31'h0, irq_out}, 32'h1);
    @(negedge clk);
    chk("R9 dropped", {31'h0, irq_out}, 32'h0);

    // R8 completion and clear on the same bit in the same cycle
    wr(8'h90, 32'h08);
    reg_addr = 8'h94; reg_wdata = 32'h08; reg_wr = 1'b1;
    cmpl_pulse = 8'h08; cmpl_irq_ctl = 16'h00C0;
    @(negedge clk);
    reg_wr = 1'b0; cmpl_pulse = '0; cmpl_irq_ctl = '0;
    rd(8'h90, v, v5); chk("R8 set wins", v, 32'h08);

    // R10 mask discovery on both instances
    wr(8'h98, 32'hFFFF_FFFF);
    rd(8'h98, v, v5);
    chk("R10 discover8", v, 32'hFF);
    chk("R10 discover5", v5, 32'h1F);
    pulse(6, 2'b11);
    rd(8'h90, v, v5); chk("R10 ctx6 in dut5", v5, 32'h08);
    chk("R10 ctx6 in dut", v, 32'h48);

    // R11 read data holds without a strobe
    rd(8'h90, v, v5);
    reg_addr = 8'h98;
    @(negedge clk);
    chk("R11 hold", reg_rdata, 32'h48);
    wr(8'h90, 32'h01);
    chk("R11 hold after wr", reg_rdata, 32'h48);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule